// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block classifies one 16-bit instruction parcel of a compact processor instruction set. The two most significant bits pick one of three encodings: a register-register encoding with an 8-bit operation code, a register-plus-byte encoding with four operations, and a conditional-branch encoding with a 4-bit condition and a 10-bit half-word offset. From the word the block separates the operation code, the register indices and the immediate or byte displacement. It also reports how many bytes the whole instruction takes, either the parcel alone or the parcel plus a trailing 32-bit literal.

For the fetch and issue logic around it, the block raises an illegal-encoding flag on undefined words. It also drives a one-hot operation class that steers the word to the ALU, load, store, branch, call, return or trap path. The literal itself is fetched elsewhere. A parameter chooses a registered output with one cycle of latency (the default) or a purely combinational path.

Top module: `insn_fmt_decoder`

## Requirements
- R1: `out_fmt` is 1 when word bit 15 is 0, 2 when bits 15:14 are `10` and 3 when bits 15:14 are `11`.
- R2: For format 1, `out_op` is word bits [15:8], `out_ra` is bits [7:4] and `out_rb` is bits [3:0]. `out_imm` and `out_disp` are 0.
- R3: For format 2, `out_op` is the 2-bit operation from bits [13:12], zero-extended (0 increment, 1 decrement, 2 read special register, 3 write special register). `out_ra` is bits [11:8], `out_imm` is bits [7:0], and `out_rb` and `out_disp` are 0.
- R4: For format 3, `out_op` is the condition from bits [13:10], zero-extended. `out_disp` is the 10-bit field [9:0] sign-extended to 16 bits and multiplied by two. `out_ra`, `out_rb` and `out_imm` are 0.
- R5: `out_len` is 6 for format 1 codes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39. It is 2 for every other word, illegal words included.
- R6: Format 1 codes outside 0x00 to 0x0E and 0x19 to 0x39 raise `out_illegal`. Every format 2 word is legal.
- R7: Format 3 words with a condition of 10 to 15 raise `out_illegal`. Conditions 0 to 9 are legal.
- R8: `out_class` bits are [0] ALU, [1] load, [2] store, [3] branch, [4] call, [5] return and [6] trap. A valid legal word sets exactly one bit. The mapping is as follows.
  - Load: format 1 codes 07, 08, 0A, 0C, 1C, 1D, 21, 22, 36, 38.
  - Store: format 1 codes 06, 09, 0B, 0D, 1E, 1F, 23, 24, 37, 39.
  - Branch: format 1 codes 1A and 25, and every legal format 3 word.
  - Call: format 1 codes 03 and 19.
  - Return: format 1 code 04.
  - Trap: format 1 codes 30 and 35.
  - ALU: every other legal word, including all of format 2.
- R9: `out_illegal` and any `out_class` bit are never high together. When the word is not valid, `out_illegal` and `out_class` are 0.
- R10: With the output registered, outputs follow the input by one clock and `out_valid` repeats `in_valid`. During reset, `out_valid`, `out_illegal` and `out_class` are 0.
- R11: Code 0x35 is a trap of length 2, and code 0x30 is a trap of length 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Word qualifier |
| in_word | input | 16 | Instruction parcel |
| out_valid | output | 1 | Output qualifier |
| out_fmt | output | 2 | Format number 1, 2 or 3 |
| out_op | output | 8 | Operation code or condition |
| out_ra | output | 4 | First register index |
| out_rb | output | 4 | Second register index |
| out_imm | output | 8 | Unsigned byte of format 2 |
| out_disp | output | 16 | Signed byte displacement of format 3 |
| out_len | output | 3 | Instruction length in bytes |
| out_illegal | output | 1 | Undefined encoding |
| out_class | output | 7 | One-hot operation class |

## Verification
The legality check and the class generation act on the same word in the same cycle, and they must never both claim it. Every one of the 65536 parcels is applied with the qualifier high. On each one the bench compares the flag, the class vector, the length and every field with a model it computes itself, so each undefined code in all three encodings meets the class logic. A second collision appears when an undefined word arrives with the qualifier low. Directed steps then require both the flag and the class to stay at zero.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 8;
    localparam int REG_W  = 4;
    localparam int IMM_W  = 8;
    localparam int OFF_W  = 10;
    localparam int DISP_W = 16;
    localparam int LEN_W  = 3;
    localparam int NCLS   = 7;
    localparam int COND_W = 4;
    localparam int NCOND  = 10;   // defined branch conditions 0..NCOND-1

    localparam int CLS_ALU = 0;
    localparam int CLS_LD  = 1;
    localparam int CLS_ST  = 2;
    localparam int CLS_BR  = 3;
    localparam int CLS_CALL = 4;
    localparam int CLS_RET = 5;
    localparam int CLS_TRAP = 6;

    localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
    localparam logic [LEN_W-1:0] LEN_LONG  = 3'd6;

    typedef enum logic [1:0] {
        FMT_NONE  = 2'd0,
        FMT_ONE   = 2'd1,
        FMT_TWO   = 2'd2,
        FMT_THREE = 2'd3
    } fmt_e;

    typedef struct packed {
        logic                vld;
        fmt_e                fmt;
        logic [CODE_W-1:0]   op;
        logic [REG_W-1:0]    ra;
        logic [REG_W-1:0]    rb;
        logic [IMM_W-1:0]    imm;
        logic [DISP_W-1:0]   disp;
        logic [LEN_W-1:0]    len;
        logic                ill;
        logic [NCLS-1:0]     cls;
    } dec_t;
endpackage

// File: rtl/insn_f1_table.sv
module insn_f1_table
    import insn_dec_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic              legal_o,
    output logic              long_o,
    output logic [NCLS-1:0]   cls_o
);
    always_comb begin
        legal_o = 1'b1;
        long_o  = 1'b0;
        cls_o   = '0;
        case (code_i) inside
            8'h00, 8'h02, 8'h05, 8'h0e, [8'h26:8'h2f], [8'h31:8'h34]:
                cls_o[CLS_ALU] = 1'b1;
            8'h01, 8'h1b, 8'h20: begin
                cls_o[CLS_ALU] = 1'b1;
                long_o         = 1'b1;
            end
            8'h07, 8'h0a, 8'h1c, 8'h21:
                cls_o[CLS_LD] = 1'b1;
            8'h08, 8'h0c, 8'h1d, 8'h22, 8'h36, 8'h38: begin
                cls_o[CLS_LD] = 1'b1;
                long_o        = 1'b1;
            end
            8'h06, 8'h0b, 8'h1e, 8'h23:
                cls_o[CLS_ST] = 1'b1;
            8'h09, 8'h0d, 8'h1f, 8'h24, 8'h37, 8'h39: begin
                cls_o[CLS_ST] = 1'b1;
                long_o        = 1'b1;
            end
            8'h25: cls_o[CLS_BR] = 1'b1;
            8'h1a: begin
                cls_o[CLS_BR] = 1'b1;
                long_o        = 1'b1;
            end
            8'h19: cls_o[CLS_CALL] = 1'b1;
            8'h03: begin
                cls_o[CLS_CALL] = 1'b1;
                long_o          = 1'b1;
            end
            8'h04: cls_o[CLS_RET] = 1'b1;
            8'h35: cls_o[CLS_TRAP] = 1'b1;
            8'h30: begin
                cls_o[CLS_TRAP] = 1'b1;
                long_o          = 1'b1;
            end
            default: legal_o = 1'b0;
        endcase
    end

    // R5: a literal-carrying code is always a defined one
    always_comb begin
        p_long_legal_r5: assert (!long_o || legal_o);
    end
endmodule

// File: rtl/insn_field_split.sv
module insn_field_split
    import insn_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fmt_e              fmt_o,
    output logic [CODE_W-1:0] op_o,
    output logic [REG_W-1:0]  ra_o,
    output logic [REG_W-1:0]  rb_o,
    output logic [IMM_W-1:0]  imm_o,
    output logic [DISP_W-1:0] disp_o,
    output logic              cond_bad_o
);
    localparam int EXT_W = DISP_W - OFF_W - 1;

    logic [COND_W-1:0] cond;

    always_comb begin
        op_o   = '0;
        ra_o   = '0;
        rb_o   = '0;
        imm_o  = '0;
        disp_o = '0;
        cond   = word_i[13:10];
        cond_bad_o = 1'b0;
        if (!word_i[15]) begin
            fmt_o = FMT_ONE;
            op_o  = word_i[15:8];
            ra_o  = word_i[7:4];
            rb_o  = word_i[3:0];
        end else if (!word_i[14]) begin
            fmt_o = FMT_TWO;
            op_o  = {{(CODE_W-2){1'b0}}, word_i[13:12]};
            ra_o  = word_i[11:8];
            imm_o = word_i[7:0];
        end else begin
            fmt_o      = FMT_THREE;
            op_o       = {{(CODE_W-COND_W){1'b0}}, cond};
            disp_o     = {{EXT_W{word_i[OFF_W-1]}}, word_i[OFF_W-1:0], 1'b0};
            cond_bad_o = (int'(cond) >= NCOND);
        end
    end
endmodule

// File: rtl/insn_fmt_decoder.sv
module insn_fmt_decoder
    import insn_dec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       in_word,
    output logic              out_valid,
    output logic [1:0]        out_fmt,
    output logic [7:0]        out_op,
    output logic [3:0]        out_ra,
    output logic [3:0]        out_rb,
    output logic [7:0]        out_imm,
    output logic [15:0]       out_disp,
    output logic [2:0]        out_len,
    output logic              out_illegal,
    output logic [6:0]        out_class
);
    fmt_e              fmt_w;
    logic [CODE_W-1:0] op_w;
    logic [REG_W-1:0]  ra_w, rb_w;
    logic [IMM_W-1:0]  imm_w;
    logic [DISP_W-1:0] disp_w;
    logic              cond_bad_w;
    logic              f1_legal, f1_long;
    logic [NCLS-1:0]   f1_cls;

    dec_t dec_d, dec_q;

    insn_field_split u_split (
        .word_i     (in_word),
        .fmt_o      (fmt_w),
        .op_o       (op_w),
        .ra_o       (ra_w),
        .rb_o       (rb_w),
        .imm_o      (imm_w),
        .disp_o     (disp_w),
        .cond_bad_o (cond_bad_w)
    );

    insn_f1_table u_f1 (
        .code_i  (in_word[15:8]),
        .legal_o (f1_legal),
        .long_o  (f1_long),
        .cls_o   (f1_cls)
    );

    always_comb begin
        dec_d      = '0;
        dec_d.vld  = in_valid;
        dec_d.fmt  = fmt_w;
        dec_d.op   = op_w;
        dec_d.ra   = ra_w;
        dec_d.rb   = rb_w;
        dec_d.imm  = imm_w;
        dec_d.disp = disp_w;
        dec_d.len  = (fmt_w == FMT_ONE && f1_long) ? LEN_LONG : LEN_SHORT;
        unique case (fmt_w)
            FMT_ONE:   dec_d.ill = in_valid && !f1_legal;
            FMT_THREE: dec_d.ill = in_valid && cond_bad_w;
            default:   dec_d.ill = 1'b0;
        endcase
        if (in_valid && !dec_d.ill) begin
            unique case (fmt_w)
                FMT_ONE:   dec_d.cls = f1_cls;
                FMT_THREE: dec_d.cls[CLS_BR] = 1'b1;
                default:   dec_d.cls[CLS_ALU] = 1'b1;
            endcase
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dec_q <= '0;
                else        dec_q <= dec_d;
            end

            // R10: qualifier is delayed by exactly one clock
            p_lat_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            p_lat_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
        end else begin : g_comb
            assign dec_q = dec_d;
        end
    endgenerate

    assign out_valid   = dec_q.vld;
    assign out_fmt     = dec_q.fmt;
    assign out_op      = dec_q.op;
    assign out_ra      = dec_q.ra;
    assign out_rb      = dec_q.rb;
    assign out_imm     = dec_q.imm;
    assign out_disp    = dec_q.disp;
    assign out_len     = dec_q.len;
    assign out_illegal = dec_q.ill;
    assign out_class   = dec_q.cls;

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_class == '0));
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_class == '0 && !out_illegal));
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal) |-> ($countones(out_class) == 1));
    p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == LEN_SHORT || out_len == LEN_LONG));
    p_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt == FMT_THREE && out_op >= NCOND) |-> out_illegal);
    p_swi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt == FMT_ONE && out_op == 8'h30)
            |-> (out_len == LEN_LONG && out_class[CLS_TRAP]));
endmodule

// File: tb/sim_insn_fmt_decoder.sv
`timescale 1ns/1ps
module sim_insn_fmt_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic out_valid, out_illegal;
    logic [1:0] out_fmt;
    logic [7:0] out_op, out_imm;
    logic [3:0] out_ra, out_rb;
    logic [15:0] out_disp;
    logic [2:0] out_len;
    logic [6:0] out_class;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    insn_fmt_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_fmt(out_fmt), .out_op(out_op),
        .out_ra(out_ra), .out_rb(out_rb), .out_imm(out_imm),
        .out_disp(out_disp), .out_len(out_len), .out_illegal(out_illegal),
        .out_class(out_class)
    );

    // word, fmt, len, illegal, class
    localparam int NV = 14;
    localparam logic [28:0] VEC [NV] = '{
        {16'h0000, 2'd1, 3'd2, 1'b0, 7'b0000001},  // R8 nop as ALU
        {16'h0130, 2'd1, 3'd6, 1'b0, 7'b0000001},  // R5 long ALU
        {16'h0312, 2'd1, 3'd6, 1'b0, 7'b0010000},  // R8 call
        {16'h0400, 2'd1, 3'd2, 1'b0, 7'b0100000},  // R8 return
        {16'h0F00, 2'd1, 3'd2, 1'b1, 7'b0000000},  // R6 just above range
        {16'h1800, 2'd1, 3'd2, 1'b1, 7'b0000000},  // R6 just below range
        {16'h3000, 2'd1, 3'd6, 1'b0, 7'b1000000},  // R11 long trap
        {16'h3500, 2'd1, 3'd2, 1'b0, 7'b1000000},  // R11 short trap
        {16'h3A00, 2'd1, 3'd2, 1'b1, 7'b0000000},  // R6 past top
        {16'h39AB, 2'd1, 3'd6, 1'b0, 7'b0000100},  // R5 long store
        {16'h8123, 2'd2, 3'd2, 1'b0, 7'b0000001},  // R3 format 2
        {16'hC3FF, 2'd3, 3'd2, 1'b0, 7'b0001000},  // R4 branch
        {16'hE800, 2'd3, 3'd2, 1'b1, 7'b0000000},  // R7 cond 10
        {16'hE400, 2'd3, 3'd2, 1'b0, 7'b0001000}   // R7 cond 9
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s word=%h act=%h exp=%h", req, in_word, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] w, input logic v);
        @(negedge clk);
        in_word  = w;
        in_valid = v;
        @(posedge clk);
        #1;
    endtask

    function automatic void model(input logic [15:0] w, output logic [1:0] f,
            output logic [7:0] op, output logic [3:0] ra, output logic [3:0] rb,
            output logic [7:0] imm, output logic [15:0] disp, output logic [2:0] len,
            output logic ill, output logic [6:0] cls);
        logic [7:0] c;
        int cond;
        c = w[15:8];
        op = 0; ra = 0; rb = 0; imm = 0; disp = 0; len = 2; ill = 0; cls = 0;
        if (w[15] == 1'b0) begin
            f = 1; op = c; ra = w[7:4]; rb = w[3:0];
            if (c inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B, 8'h1D,
                          8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39})
                len = 6;
            if (!((c <= 8'h0E) || (c >= 8'h19 && c <= 8'h39))) ill = 1;
            else if (c inside {8'h07, 8'h08, 8'h0A, 8'h0C, 8'h1C, 8'h1D, 8'h21, 8'h22, 8'h36, 8'h38}) cls = 7'b0000010;
            else if (c inside {8'h06, 8'h09, 8'h0B, 8'h0D, 8'h1E, 8'h1F, 8'h23, 8'h24, 8'h37, 8'h39}) cls = 7'b0000100;
            else if (c == 8'h1A || c == 8'h25) cls = 7'b0001000;
            else if (c == 8'h03 || c == 8'h19) cls = 7'b0010000;
            else if (c == 8'h04) cls = 7'b0100000;
            else if (c == 8'h30 || c == 8'h35) cls = 7'b1000000;
            else cls = 7'b0000001;
        end else if (w[14] == 1'b0) begin
            f = 2; op = {6'd0, w[13:12]}; ra = w[11:8]; imm = w[7:0]; cls = 7'b0000001;
        end else begin
            f = 3;
            cond = int'(w[13:10]);
            op = 8'(cond);
            disp = 16'(int'($signed(w[9:0])) * 2);
            if (cond > 9) ill = 1; else cls = 7'b0001000;
        end
    endfunction

    initial begin
        #(5ns * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R10 act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] ef; logic [7:0] eop, eimm; logic [3:0] era, erb;
        logic [15:0] edisp; logic [2:0] elen; logic eill; logic [6:0] ecls;

        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 0 && out_illegal == 0 && out_class == 0, "R10 reset",
              {out_valid, out_illegal, out_class}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table of directed vectors: R1 R5 R6 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][28:13], 1'b1);
            check({out_fmt, out_len, out_illegal, out_class} == VEC[i][12:0],
                  "R1/R5/R6/R7/R8/R11 table", {out_fmt, out_len, out_illegal, out_class}, VEC[i][12:0]);
        end

        // full sweep: R1 R2 R3 R4 R5 R6 R7 R8 against the bench model
        for (int w = 0; w < 65536; w++) begin
            apply(16'(w), 1'b1);
            model(16'(w), ef, eop, era, erb, eimm, edisp, elen, eill, ecls);
            check({out_valid, out_fmt, out_op, out_ra, out_rb, out_imm, out_disp, out_len, out_illegal, out_class}
                  == {1'b1, ef, eop, era, erb, eimm, edisp, elen, eill, ecls},
                  "R1/R2/R3/R4/R5/R6/R7/R8 sweep",
                  {out_fmt, out_op, out_ra, out_rb, out_imm, out_disp, out_len, out_illegal, out_class},
                  {ef, eop, era, erb, eimm, edisp, elen, eill, ecls});
        end

        // R9: illegal words with qualifier low give no flag and no class
        apply(16'h0F00, 1'b0);
        check(!out_valid && !out_illegal && out_class == 0, "R9 idle illegal f1",
              {out_valid, out_illegal, out_class}, 0);
        apply(16'hFC00, 1'b0);
        check(!out_valid && !out_illegal && out_class == 0, "R9 idle illegal f3",
              {out_valid, out_illegal, out_class}, 0);
        apply(16'h3000, 1'b0);
        check(out_class == 0, "R9 idle legal", out_class, 0);

        // R10: qualifier returns after one clock; R4 negative displacement
        apply(16'hC200, 1'b1);
        check(out_valid && out_disp == 16'hFC00, "R10/R4 latency and sign",
              {out_valid, out_disp}, {1'b1, 16'hFC00});
        apply(16'hC1FF, 1'b1);
        check(out_disp == 16'h03FE, "R4 max forward", out_disp, 16'h03FE);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule